// File: doc/BRIEF.md
# Center-Aligned Asymmetric PWM Timebase

This block is the counting engine behind one PWM output. A 16-bit counter either counts down from the period value to zero and reloads (edge-aligned type), or counts up from zero to the period value and back down again (center-aligned type). The counter is compared against a duty value to produce a raw PWM level. In center-aligned type it can run asymmetric, using one compare value on the rising slope and another on the falling slope. Four single-cycle event pulses mark the period point, the centre point, and the matches of the two compare values.

Software writes the period and the compare values into shadow registers. They only move into the active registers at an update point, so a cycle already in progress never changes. A two-bit selector picks the update point in center-aligned type: the top of the count, the bottom, or both. The counter advances only on cycles where the prescaler tick is high and the run enable is set. One-shot mode stops the counter after one PWM cycle. A clear input sends the counter back to its start state.

Top module: `ctpwm_timebase`

## Requirements
- R1: With `center_mode`=0, each advancing tick moves the count down by one. A tick from count 0 reloads the active period. `count_up` stays 0.
- R2: With `center_mode`=1, the count rises by one per tick to the active period, then falls by one per tick to 0, then rises again. `count_up` is 1 for values reached while rising and 0 for values reached while falling.
- R3: `ev_period` pulses for one cycle together with the count value that causes it. In edge-aligned type that value is 0. In center-aligned type it is the period value reached while rising. `ev_centre` pulses only in center-aligned type, when the count reaches 0 while falling. The two never pulse together.
- R4: `ev_cmp_dn` pulses when a falling or reloaded count equals the down compare. `ev_cmp_up` pulses only in center-aligned type, when a rising count equals the up-slope compare.
- R5: `pwm_raw` is 1 exactly while the count is below the compare for the current slope. The down compare is `cmp_data[15:0]`. The up-slope compare is `cmp_data[31:16]` when `asym_mode`=1 and center-aligned type is selected, and the down compare otherwise.
- R6: A compare of 0 keeps `pwm_raw` at 0 for the whole cycle. A compare above the period keeps it at 1.
- R7: A period or compare write goes to a shadow register. The active values change only at an update point. In edge-aligned type that point is the reload tick from count 0.
- R8: In center-aligned type, `upd_sel` 00 and 11 load the shadows on the tick leaving the top. 01 loads on the tick leaving 0 while falling. 10 loads at both points.
- R9: While the active period is 0, the shadows load on every advancing tick, whatever `upd_sel` is.
- R10: With `one_shot`=1 the counter stops after the first period event and holds. Dropping `run` re-arms it. With `one_shot`=0 it runs on.
- R11: While `run` or `tick` is 0, the count, the direction and the active values hold, and no event pulses.
- R12: `cnt_clr` high at a clock edge sets the count to 0 and the direction to falling, and suppresses every event on that edge. The next advancing tick starts a new cycle.
- R13: After reset, the count is 0, `count_up` is 0, `pwm_raw` is 0 and no event is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler enable; the counter advances only when high |
| run | input | 1 | Run enable |
| center_mode | input | 1 | 0 edge-aligned, 1 center-aligned |
| asym_mode | input | 1 | Separate up-slope compare in center-aligned type |
| one_shot | input | 1 | Stop after one cycle |
| upd_sel | input | 2 | Shadow update point selector |
| cnt_clr | input | 1 | Counter clear command |
| per_wr | input | 1 | Period shadow write strobe |
| per_data | input | 16 | Period write data |
| cmp_wr | input | 1 | Compare shadow write strobe |
| cmp_data | input | 32 | [15:0] down compare, [31:16] up-slope compare |
| pwm_raw | output | 1 | Raw PWM level |
| count | output | 16 | Current count |
| count_up | output | 1 | 1 while rising, 0 while falling |
| ev_period | output | 1 | Period event pulse |
| ev_centre | output | 1 | Centre event pulse |
| ev_cmp_dn | output | 1 | Down-slope compare event pulse |
| ev_cmp_up | output | 1 | Up-slope compare event pulse |

## Verification
The count, the direction and all four event pulses are registered on the same edge, so each appears one clock after the tick that causes it. `pwm_raw` is decoded from the registers in that same cycle. A shadow write is captured on one edge and reaches the active registers at the next update point, so its effect can appear no earlier than two edges after the write. The bench drives inputs and samples outputs on the falling clock edge. It follows each scenario one rising edge at a time and compares each value against a sequence worked out from the requirements.

// File: rtl/ctpwm_pkg.sv
package ctpwm_pkg;

  typedef enum logic [1:0] {
    UPD_TOP     = 2'b00,
    UPD_BOTTOM  = 2'b01,
    UPD_BOTH    = 2'b10,
    UPD_TOP_ALT = 2'b11
  } upd_sel_e;

  typedef struct packed {
    logic period;
    logic centre;
    logic cmp_dn;
    logic cmp_up;
  } pwm_evt_t;

  // Decide whether the current tick is an update point for the shadows.
  function automatic logic load_point(upd_sel_e sel, logic ctr,
                                      logic at_bottom, logic at_top);
    if (!ctr) return at_bottom;
    case (sel)
      UPD_BOTTOM: return at_bottom;
      UPD_BOTH:   return at_bottom | at_top;
      default:    return at_top;
    endcase
  endfunction

endpackage

// File: rtl/ctpwm_counter.sv
module ctpwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          cnt_clr,
  input  logic          run,
  input  logic          center,
  input  logic          one_shot,
  input  logic [CW-1:0] per_next,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          halted_q,
  output logic [CW-1:0] cnt_d,
  output logic          dir_d,
  output logic          hit_period
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  // Next {direction, count} for one advancing tick.
  function automatic logic [CW:0] next_step(logic [CW-1:0] c, logic up,
                                            logic [CW-1:0] p, logic ctr);
    if (!ctr) return (c == ZERO) ? {1'b0, p} : {1'b0, c - ONE};
    if (!up) begin
      if (c != ZERO) return {1'b0, c - ONE};
      if (p == ZERO) return {1'b0, ZERO};
      return {1'b1, ONE};
    end
    if (c >= p) return (c == ZERO) ? {1'b0, ZERO} : {1'b0, c - ONE};
    return {1'b1, c + ONE};
  endfunction

  // Period point reached by the new count.
  function automatic logic period_hit(logic [CW-1:0] c, logic up,
                                      logic [CW-1:0] p, logic ctr);
    if (!ctr) return c == ZERO;
    return up && (c == p);
  endfunction

  logic [CW:0] step_w;

  always_comb begin
    step_w     = next_step(cnt_q, dir_q, per_next, center);
    dir_d      = step_w[CW];
    cnt_d      = step_w[CW-1:0];
    hit_period = period_hit(cnt_d, dir_d, per_next, center);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= ZERO;
      dir_q    <= 1'b0;
      halted_q <= 1'b0;
    end else if (cnt_clr) begin
      cnt_q    <= ZERO;
      dir_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      if (!run) halted_q <= 1'b0;
      if (step_en) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
        if (one_shot && hit_period) halted_q <= 1'b1;
      end
    end
  end

  assert_edge_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !center) |=> !dir_q);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cnt_clr) |=> ($stable(cnt_q) && $stable(dir_q)));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == ZERO && !dir_q));

  assert_oneshot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !cnt_clr) |=> $stable(cnt_q));

endmodule

// File: rtl/ctpwm_shadow.sv
module ctpwm_shadow #(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            per_wr,
  input  logic [CW-1:0]   per_data,
  input  logic            cmp_wr,
  input  logic [2*CW-1:0] cmp_data,
  input  logic            load_now,
  output logic [CW-1:0]   per_act,
  output logic [CW-1:0]   cmp_dn_act,
  output logic [CW-1:0]   cmp_up_act,
  output logic [CW-1:0]   per_next,
  output logic [CW-1:0]   cmp_dn_next,
  output logic [CW-1:0]   cmp_up_next
);

  logic [CW-1:0] per_sh, cmp_dn_sh, cmp_up_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh    <= '0;
      cmp_dn_sh <= '0;
      cmp_up_sh <= '0;
    end else begin
      if (per_wr) per_sh <= per_data;
      if (cmp_wr) begin
        cmp_dn_sh <= cmp_data[CW-1:0];
        cmp_up_sh <= cmp_data[2*CW-1:CW];
      end
    end
  end

  always_comb begin
    per_next    = load_now ? per_sh    : per_act;
    cmp_dn_next = load_now ? cmp_dn_sh : cmp_dn_act;
    cmp_up_next = load_now ? cmp_up_sh : cmp_up_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act    <= '0;
      cmp_dn_act <= '0;
      cmp_up_act <= '0;
    end else if (load_now) begin
      per_act    <= per_sh;
      cmp_dn_act <= cmp_dn_sh;
      cmp_up_act <= cmp_up_sh;
    end
  end

  assert_shadow_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> ($stable(per_act) && $stable(cmp_dn_act) && $stable(cmp_up_act)));

endmodule

// File: rtl/ctpwm_events.sv
module ctpwm_events
  import ctpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          cnt_clr,
  input  logic          center,
  input  logic          asym,
  input  logic [CW-1:0] cnt_d,
  input  logic          dir_d,
  input  logic          hit_period,
  input  logic [CW-1:0] cnt_q,
  input  logic          dir_q,
  input  logic [CW-1:0] cmp_dn_next,
  input  logic [CW-1:0] cmp_up_next,
  input  logic [CW-1:0] cmp_dn_act,
  input  logic [CW-1:0] cmp_up_act,
  output pwm_evt_t      evt_q,
  output logic          pwm_raw
);

  // Compare that applies on the given slope.
  function automatic logic [CW-1:0] slope_cmp(logic up, logic asym_eff,
                                              logic [CW-1:0] cdn,
                                              logic [CW-1:0] cup);
    return (up && asym_eff) ? cup : cdn;
  endfunction

  logic     asym_eff;
  pwm_evt_t evt_d;

  always_comb begin
    asym_eff     = center & asym;
    evt_d.period = hit_period;
    evt_d.centre = center && !dir_d && (cnt_d == '0);
    evt_d.cmp_dn = !dir_d && (cnt_d == cmp_dn_next);
    evt_d.cmp_up = center && dir_d &&
                   (cnt_d == slope_cmp(1'b1, asym_eff, cmp_dn_next, cmp_up_next));
    pwm_raw      = cnt_q < slope_cmp(dir_q, asym_eff, cmp_dn_act, cmp_up_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  evt_q <= '0;
    else if (step_en && !cnt_clr) evt_q <= evt_d;
    else                         evt_q <= '0;
  end

  assert_evt_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_q.period, evt_q.centre}));

  assert_centre_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.centre |-> (cnt_q == '0 && !dir_q));

  assert_cmpup_slope_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q.cmp_up |-> dir_q);

endmodule

// File: rtl/ctpwm_timebase.sv
module ctpwm_timebase
  import ctpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic            center_mode,
  input  logic            asym_mode,
  input  logic            one_shot,
  input  logic [1:0]      upd_sel,
  input  logic            cnt_clr,
  input  logic            per_wr,
  input  logic [CW-1:0]   per_data,
  input  logic            cmp_wr,
  input  logic [2*CW-1:0] cmp_data,
  output logic            pwm_raw,
  output logic [CW-1:0]   count,
  output logic            count_up,
  output logic            ev_period,
  output logic            ev_centre,
  output logic            ev_cmp_dn,
  output logic            ev_cmp_up
);

  logic [CW-1:0] cnt_q, cnt_d, per_act, cmp_dn_act, cmp_up_act;
  logic [CW-1:0] per_next, cmp_dn_next, cmp_up_next;
  logic          dir_q, dir_d, halted_q, hit_period;
  logic          step_en, at_bottom, at_top, load_now;
  pwm_evt_t      evt_q;

  always_comb begin
    step_en   = tick & run & ~halted_q & ~cnt_clr;
    at_bottom = (cnt_q == '0) & ~dir_q;
    at_top    = center_mode & dir_q & (cnt_q >= per_act);
    load_now  = step_en & (load_point(upd_sel_e'(upd_sel), center_mode,
                                      at_bottom, at_top) | (per_act == '0));
  end

  ctpwm_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .per_wr(per_wr), .per_data(per_data),
    .cmp_wr(cmp_wr), .cmp_data(cmp_data),
    .load_now(load_now),
    .per_act(per_act), .cmp_dn_act(cmp_dn_act), .cmp_up_act(cmp_up_act),
    .per_next(per_next), .cmp_dn_next(cmp_dn_next), .cmp_up_next(cmp_up_next)
  );

  ctpwm_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n),
    .step_en(step_en), .cnt_clr(cnt_clr), .run(run),
    .center(center_mode), .one_shot(one_shot), .per_next(per_next),
    .cnt_q(cnt_q), .dir_q(dir_q), .halted_q(halted_q),
    .cnt_d(cnt_d), .dir_d(dir_d), .hit_period(hit_period)
  );

  ctpwm_events #(.CW(CW)) u_events (
    .clk(clk), .rst_n(rst_n),
    .step_en(step_en), .cnt_clr(cnt_clr),
    .center(center_mode), .asym(asym_mode),
    .cnt_d(cnt_d), .dir_d(dir_d), .hit_period(hit_period),
    .cnt_q(cnt_q), .dir_q(dir_q),
    .cmp_dn_next(cmp_dn_next), .cmp_up_next(cmp_up_next),
    .cmp_dn_act(cmp_dn_act), .cmp_up_act(cmp_up_act),
    .evt_q(evt_q), .pwm_raw(pwm_raw)
  );

  assign count     = cnt_q;
  assign count_up  = dir_q;
  assign ev_period = evt_q.period;
  assign ev_centre = evt_q.centre;
  assign ev_cmp_dn = evt_q.cmp_dn;
  assign ev_cmp_up = evt_q.cmp_up;

endmodule

// File: tb/ctpwm_timebase_test.sv
module ctpwm_timebase_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick, run, center_mode, asym_mode, one_shot, cnt_clr;
  logic [1:0]  upd_sel;
  logic        per_wr, cmp_wr;
  logic [15:0] per_data;
  logic [31:0] cmp_data;
  logic        pwm_raw, count_up, ev_period, ev_centre, ev_cmp_dn, ev_cmp_up;
  logic [15:0] count;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ctpwm_timebase uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .center_mode(center_mode), .asym_mode(asym_mode), .one_shot(one_shot),
    .upd_sel(upd_sel), .cnt_clr(cnt_clr),
    .per_wr(per_wr), .per_data(per_data), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
    .pwm_raw(pwm_raw), .count(count), .count_up(count_up),
    .ev_period(ev_period), .ev_centre(ev_centre),
    .ev_cmp_dn(ev_cmp_dn), .ev_cmp_up(ev_cmp_up)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b1; run = 1'b0; center_mode = 1'b0; asym_mode = 1'b0;
    one_shot = 1'b0; cnt_clr = 1'b0; upd_sel = 2'b00;
    per_wr = 1'b0; cmp_wr = 1'b0; per_data = '0; cmp_data = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_per(input int v);
    per_wr = 1'b1; per_data = 16'(v);
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  task automatic wr_cmp(input int up, input int dn);
    cmp_wr = 1'b1; cmp_data = {16'(up), 16'(dn)};
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R13 reset count", count, 0);
    chk("R13 reset dir", count_up, 0);
    chk("R13 reset pwm", pwm_raw, 0);
    chk("R13 reset events", {ev_period, ev_centre, ev_cmp_dn, ev_cmp_up}, 0);
  endtask

  task automatic test_edge();
    int e;
    do_reset(); wr_per(4); wr_cmp(0, 2); run = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      e = 4 - ((k - 1) % 5);
      chk("R1 edge count", count, e);
      chk("R1 edge dir", count_up, 0);
      chk("R3 edge period event", ev_period, int'(e == 0));
      chk("R3 no centre in edge", ev_centre, 0);
      chk("R4 edge cmp_dn event", ev_cmp_dn, int'(e == 2));
      chk("R4 no cmp_up in edge", ev_cmp_up, 0);
      chk("R5 edge pwm", pwm_raw, int'(e < 2));
    end
  endtask

  task automatic test_center(input int p, input int cdn, input int cup, input bit as);
    int ph, c, up, ac;
    do_reset(); wr_per(p); wr_cmp(cup, cdn);
    center_mode = 1'b1; asym_mode = as; run = 1'b1;
    for (int k = 1; k <= 4 * p; k++) begin
      @(negedge clk);
      ph = (k - 1) % (2 * p);
      up = int'(ph < p);
      c  = (ph < p) ? ph + 1 : 2 * p - 1 - ph;
      ac = (up != 0 && as) ? cup : cdn;
      chk("R2 center count", count, c);
      chk("R2 center dir", count_up, up);
      chk("R3 center period event", ev_period, int'(up != 0 && c == p));
      chk("R3 centre event", ev_centre, int'(up == 0 && c == 0));
      chk("R4 center cmp_dn event", ev_cmp_dn, int'(up == 0 && c == cdn));
      chk("R4 center cmp_up event", ev_cmp_up, int'(up != 0 && c == ac));
      chk("R5 center pwm", pwm_raw, int'(c < ac));
    end
  endtask

  task automatic test_shadow_edge();
    do_reset(); wr_per(3); wr_cmp(0, 0); run = 1'b1;
    @(negedge clk); chk("R7 first count", count, 3);
    per_wr = 1'b1; per_data = 16'd6; cmp_wr = 1'b1; cmp_data = {16'd0, 16'd10};
    @(negedge clk); per_wr = 1'b0; cmp_wr = 1'b0;
    chk("R7 no mid-cycle period", count, 2);
    chk("R7 old compare kept", pwm_raw, 0);
    @(negedge clk); chk("R7 count 1", count, 1); chk("R7 pwm at 1", pwm_raw, 0);
    @(negedge clk); chk("R7 count 0", count, 0); chk("R7 pwm at 0", pwm_raw, 0);
    @(negedge clk); chk("R7 new period at reload", count, 6);
    chk("R6 compare above period", pwm_raw, 1);
    @(negedge clk); chk("R7 continues from new period", count, 5);
  endtask

  task automatic test_upd(input int sel, input int exp_2d, input int exp_1u);
    do_reset(); wr_per(4); wr_cmp(0, 0);
    center_mode = 1'b1; upd_sel = 2'(sel); run = 1'b1;
    @(negedge clk); chk("R8 start count", count, 1);
    cmp_wr = 1'b1; cmp_data = {16'd3, 16'd3};
    @(negedge clk); cmp_wr = 1'b0;
    chk("R8 up slope keeps old compare", pwm_raw, 0);
    @(negedge clk); @(negedge clk);
    @(negedge clk); chk("R8 falling 3", count, 3); chk("R8 falling dir", count_up, 0);
    cmp_wr = 1'b1; cmp_data = {16'd1, 16'd1};
    @(negedge clk); cmp_wr = 1'b0;
    chk("R8 falling 2 count", count, 2);
    chk($sformatf("R8 sel %0d pwm after top", sel), pwm_raw, exp_2d);
    @(negedge clk); @(negedge clk);
    @(negedge clk); chk("R8 rising 1", count, 1); chk("R8 rising dir", count_up, 1);
    chk($sformatf("R8 sel %0d pwm after bottom", sel), pwm_raw, exp_1u);
  endtask

  task automatic test_duty_limits();
    do_reset(); wr_per(3); wr_cmp(0, 0); run = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chk("R6 zero compare pwm low", pwm_raw, 0);
    end
    do_reset(); wr_per(3); wr_cmp(0, 9); run = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chk("R6 compare above period pwm high", pwm_raw, 1);
    end
  endtask

  task automatic test_one_shot();
    int np;
    do_reset(); wr_per(3); one_shot = 1'b1; run = 1'b1; np = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k < 4) chk("R10 edge one-shot count", count, 3 - k);
      if (ev_period) np++;
    end
    chk("R10 edge one-shot holds 0", count, 0);
    chk("R10 edge one period event", np, 1);
    run = 1'b0; @(negedge clk); run = 1'b1;
    @(negedge clk); chk("R10 re-armed reload", count, 3);
    do_reset(); wr_per(3); center_mode = 1'b1; one_shot = 1'b1; run = 1'b1; np = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ev_period) np++;
    end
    chk("R10 center one-shot holds top", count, 3);
    chk("R10 center one-shot dir", count_up, 1);
    chk("R10 center one period event", np, 1);
  endtask

  task automatic test_hold();
    do_reset(); wr_per(4); wr_cmp(0, 2); center_mode = 1'b1; run = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 pre-hold count", count, 2);
    run = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11 run low holds count", count, 2);
      chk("R11 run low no events", {ev_period, ev_centre, ev_cmp_dn, ev_cmp_up}, 0);
    end
    run = 1'b1; tick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 tick low holds count", count, 2);
      chk("R11 tick low no events", {ev_period, ev_centre, ev_cmp_dn, ev_cmp_up}, 0);
    end
    tick = 1'b1;
    @(negedge clk); chk("R11 resumes", count, 3);
    @(negedge clk); chk("R11 resumes to top", count, 4);
    chk("R11 period after resume", ev_period, 1);
  endtask

  task automatic test_clear();
    do_reset(); wr_per(5); run = 1'b1;
    @(negedge clk); @(negedge clk); chk("R12 edge pre-clear", count, 4);
    cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk("R12 edge cleared count", count, 0);
    chk("R12 edge clear no period event", ev_period, 0);
    @(negedge clk); chk("R12 edge restart reload", count, 5);
    do_reset(); wr_per(4); center_mode = 1'b1; run = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R12 center pre-clear", count, 3);
    cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk("R12 center cleared count", count, 0);
    chk("R12 center cleared dir", count_up, 0);
    chk("R12 center clear no centre event", ev_centre, 0);
    @(negedge clk); chk("R12 center restart count", count, 1);
    chk("R12 center restart dir", count_up, 1);
  endtask

  task automatic test_zero_period();
    do_reset(); center_mode = 1'b1; upd_sel = 2'b00; run = 1'b1;
    @(negedge clk); chk("R9 idle at zero period", count, 0);
    per_wr = 1'b1; per_data = 16'd2;
    @(negedge clk); per_wr = 1'b0;
    chk("R9 write not yet active", count, 0);
    @(negedge clk); chk("R9 zero period loads at once", count, 1);
    chk("R9 rising after load", count_up, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_edge();
    test_center(4, 2, 2, 1'b0);
    test_center(6, 1, 4, 1'b1);
    test_shadow_edge();
    test_upd(0, 1, 1);
    test_upd(1, 0, 0);
    test_upd(2, 1, 0);
    test_upd(3, 1, 1);
    test_duty_limits();
    test_one_shot();
    test_hold();
    test_clear();
    test_zero_period();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule